// File: doc/BRIEF.md
# Oneshot Trigger Pacing Scheduler

This block decides when to fire the trigger strobes for a set of output groups whose pulses are launched on demand (single-shot or serial-frame outputs) rather than by a free-running timer. Each update presents three things: a request pulse, a mask of the groups that want a trigger, and the widest pulse of the update in microseconds. The block keeps its own free microsecond time base, which it derives from the system clock through a parameterised divider. It raises one strobe per masked group when firing is allowed.

After every trigger the block computes the earliest time at which the next one may start. That time is the widest pulse plus a guard gap, so a pulse that is still on the wire is never cut short. A request that arrives too early is held and fires exactly when the window opens. While it is held, any further request is dropped. If updates stop arriving, a keep-alive timer fires the last mask again, so the groups keep a minimum refresh rate.

Top module: `pace_trigger_sched`

## Requirements
- R1: A widest-pulse input above MAX_PULSE_US (default 2300) is treated as exactly MAX_PULSE_US.
- R2: When a trigger fires at microsecond T, the earliest next trigger is T + clamped widest pulse + GUARD_US (default 50).
- R3: A request with a non-zero mask fires one clock after it is sampled if no trigger has yet occurred or the current time is at or past the earliest allowed time. Otherwise it is held and fires at the first clock edge at which the time base equals the earliest allowed time.
- R4: With a non-zero stored mask and no held request, the block fires the stored mask by itself once the time base exceeds the earliest allowed time by more than KEEPALIVE_US (default 10000). This repeats with every new window.
- R5: No keep-alive trigger occurs before the first trigger since reset. A request with a zero mask is accepted, produces no strobe and stops the keep-alive.
- R6: A request that arrives while an earlier one is held is dropped. Its mask and width have no effect, and it produces no strobe of its own.
- R7: Bit g of trig_o is strobe g. On a trigger, every bit that is set in the mask goes high together for exactly one clock, and every other bit stays low.
- R8: now_us_o starts at 0 after reset and increases by one every CLK_PER_US clocks.
- R9: During and right after reset, trig_o is all zero and now_us_o is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_req_i | input | 1 | One-clock update request |
| upd_mask_i | input | NUM_GROUPS | Groups that need a trigger for this update |
| upd_width_i | input | WIDTH_W | Widest pulse of this update in microseconds |
| trig_o | output | NUM_GROUPS | One-clock trigger strobe per group |
| now_us_o | output | TIME_W | Free-running microsecond time base |

## Verification
The hardest case to reach is a second request that lands while a first one is held behind a long window. Catching that moment takes a clamped 2300 µs pulse, so the hold lasts thousands of clocks. A dropped request must then show no trace: the first mask fires, and a quiet window follows in which no strobe of its own appears. Keep-alive refires are reached by going silent after a trigger. The bench predicts each firing microsecond from the previous firing time, the clamped width and the guard. A sweep over every non-zero mask, with widths growing past the clamp, runs back-to-back held requests.

// File: rtl/pace_pkg.sv
package pace_pkg;
  // Source that caused a trigger in the current cycle, in priority order
  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_DIRECT = 2'd1,
    SRC_HELD   = 2'd2,
    SRC_KEEP   = 2'd3
  } fire_src_e;
endpackage

// File: rtl/pace_us_base.sv
module pace_us_base #(
  parameter int CLK_PER_US = 100,
  parameter int TIME_W     = 32
) (
  input  logic              clk,
  input  logic              rst,
  output logic [TIME_W-1:0] now_o
);
  logic              tick;
  logic [TIME_W-1:0] now_q;

  generate
    if (CLK_PER_US > 1) begin : g_div
      localparam int DIV_W = $clog2(CLK_PER_US);
      localparam logic [DIV_W-1:0] LAST = DIV_W'(CLK_PER_US - 1);
      logic [DIV_W-1:0] cnt_q;

      always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
      end

      assign tick = (cnt_q == LAST);

      // R8: a microsecond tick never lasts two clocks
      p_tick_single_r8: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end else begin : g_nodiv
      assign tick = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)       now_q <= '0;
    else if (tick) now_q <= now_q + 1'b1;
  end

  assign now_o = now_q;

  // R8: the time base moves by at most one step per clock
  p_time_step_r8: assert property (@(posedge clk) disable iff (rst)
    (now_q == $past(now_q)) || (now_q == $past(now_q) + 1'b1));
endmodule

// File: rtl/pace_keepalive.sv
module pace_keepalive #(
  parameter int TIME_W       = 32,
  parameter int KEEPALIVE_US = 10000
) (
  input  logic [TIME_W-1:0] now_i,
  input  logic [TIME_W-1:0] earliest_i,
  input  logic              armed_i,
  input  logic              mask_nz_i,
  input  logic              pending_i,
  output logic              due_o
);
  logic [TIME_W-1:0] overdue;
  logic              late;

  // Signed distance past the window; negative means still inside it
  assign overdue = now_i - earliest_i;
  assign late    = !overdue[TIME_W-1] && (overdue > TIME_W'(KEEPALIVE_US));
  assign due_o   = armed_i && mask_nz_i && !pending_i && late;
endmodule

// File: rtl/pace_gate.sv
module pace_gate
  import pace_pkg::*;
#(
  parameter int NUM_GROUPS   = 4,
  parameter int TIME_W       = 32,
  parameter int WIDTH_W      = 16,
  parameter int MAX_PULSE_US = 2300,
  parameter int GUARD_US     = 50
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  upd_req_i,
  input  logic [NUM_GROUPS-1:0] upd_mask_i,
  input  logic [WIDTH_W-1:0]    upd_width_i,
  input  logic [TIME_W-1:0]     now_i,
  input  logic                  keep_due_i,
  output logic                  go_o,
  output logic [NUM_GROUPS-1:0] go_mask_o,
  output logic [TIME_W-1:0]     earliest_o,
  output logic                  armed_o,
  output logic                  mask_nz_o,
  output logic                  pending_o
);
  localparam logic [WIDTH_W-1:0] MAX_W = WIDTH_W'(MAX_PULSE_US);

  logic [NUM_GROUPS-1:0] mask_q;
  logic [WIDTH_W-1:0]    width_q;
  logic [TIME_W-1:0]     earliest_q;
  logic                  armed_q;
  logic                  pending_q;
  logic                  reached_q;

  logic [WIDTH_W-1:0]    width_clamped;
  logic [WIDTH_W-1:0]    go_width;
  logic [TIME_W-1:0]     to_window;
  logic                  reached;
  logic                  accept;
  logic                  mask_in_nz;
  logic                  held_go;
  logic                  direct_go;
  logic                  hold;
  fire_src_e             src;

  assign width_clamped = (upd_width_i > MAX_W) ? MAX_W : upd_width_i;

  // Time relative to the window; sticky flag guards against wrap on long idle
  assign to_window  = now_i - earliest_q;
  assign reached    = reached_q || !to_window[TIME_W-1];

  assign mask_in_nz = |upd_mask_i;
  assign accept     = upd_req_i && !pending_q && !keep_due_i;
  assign held_go    = pending_q && reached;
  assign direct_go  = accept && mask_in_nz && (!armed_q || reached);
  assign hold       = accept && mask_in_nz && armed_q && !reached;

  always_comb begin
    src = SRC_NONE;
    if (keep_due_i)     src = SRC_KEEP;
    else if (held_go)   src = SRC_HELD;
    else if (direct_go) src = SRC_DIRECT;
  end

  assign go_o      = (src != SRC_NONE);
  assign go_mask_o = (src == SRC_DIRECT) ? upd_mask_i    : mask_q;
  assign go_width  = (src == SRC_DIRECT) ? width_clamped : width_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q     <= '0;
      width_q    <= '0;
      earliest_q <= '0;
      armed_q    <= 1'b0;
      pending_q  <= 1'b0;
      reached_q  <= 1'b0;
    end else begin
      if (accept) begin
        mask_q  <= upd_mask_i;
        width_q <= width_clamped;
      end
      if (hold)         pending_q <= 1'b1;
      else if (held_go) pending_q <= 1'b0;
      if (go_o) begin
        earliest_q <= now_i + TIME_W'(go_width) + TIME_W'(GUARD_US);
        armed_q    <= 1'b1;
        reached_q  <= 1'b0;
      end else if (reached) begin
        reached_q  <= 1'b1;
      end
    end
  end

  assign earliest_o = earliest_q;
  assign armed_o    = armed_q;
  assign mask_nz_o  = |mask_q;
  assign pending_o  = pending_q;

  // R1: stored width never exceeds the clamp
  p_width_clamped_r1: assert property (@(posedge clk) disable iff (rst)
    width_q <= MAX_W);

  // R2: right after a trigger the window is closed again
  p_gap_after_fire_r2: assert property (@(posedge clk) disable iff (rst)
    go_o |=> !reached);

  // R6: a request during a hold leaves the held request untouched
  p_drop_while_held_r6: assert property (@(posedge clk) disable iff (rst)
    (pending_q && upd_req_i && !held_go) |=> (pending_q && $stable(mask_q) && $stable(width_q)));
endmodule

// File: rtl/pace_strobe.sv
module pace_strobe #(
  parameter int NUM_GROUPS = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  go_i,
  input  logic [NUM_GROUPS-1:0] mask_i,
  output logic [NUM_GROUPS-1:0] trig_o
);
  logic [NUM_GROUPS-1:0] trig_q;

  generate
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_lane
      always_ff @(posedge clk) begin
        if (rst) trig_q[g] <= 1'b0;
        else     trig_q[g] <= go_i && mask_i[g];
      end
    end
  endgenerate

  assign trig_o = trig_q;

  // R7: a strobe lasts exactly one clock
  p_one_clock_r7: assert property (@(posedge clk) disable iff (rst)
    (|trig_q) |=> (trig_q == '0));
endmodule

// File: rtl/pace_trigger_sched.sv
module pace_trigger_sched #(
  parameter int NUM_GROUPS   = 4,
  parameter int CLK_PER_US   = 100,
  parameter int TIME_W       = 32,
  parameter int WIDTH_W      = 16,
  parameter int MAX_PULSE_US = 2300,
  parameter int GUARD_US     = 50,
  parameter int KEEPALIVE_US = 10000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  upd_req_i,
  input  logic [NUM_GROUPS-1:0] upd_mask_i,
  input  logic [WIDTH_W-1:0]    upd_width_i,
  output logic [NUM_GROUPS-1:0] trig_o,
  output logic [TIME_W-1:0]     now_us_o
);
  logic [TIME_W-1:0]     now_us;
  logic [TIME_W-1:0]     earliest;
  logic                  armed;
  logic                  mask_nz;
  logic                  pending;
  logic                  keep_due;
  logic                  go;
  logic [NUM_GROUPS-1:0] go_mask;

  pace_us_base #(
    .CLK_PER_US (CLK_PER_US),
    .TIME_W     (TIME_W)
  ) i_base (
    .clk   (clk),
    .rst   (rst),
    .now_o (now_us)
  );

  pace_keepalive #(
    .TIME_W       (TIME_W),
    .KEEPALIVE_US (KEEPALIVE_US)
  ) i_keep (
    .now_i      (now_us),
    .earliest_i (earliest),
    .armed_i    (armed),
    .mask_nz_i  (mask_nz),
    .pending_i  (pending),
    .due_o      (keep_due)
  );

  pace_gate #(
    .NUM_GROUPS   (NUM_GROUPS),
    .TIME_W       (TIME_W),
    .WIDTH_W      (WIDTH_W),
    .MAX_PULSE_US (MAX_PULSE_US),
    .GUARD_US     (GUARD_US)
  ) i_gate (
    .clk         (clk),
    .rst         (rst),
    .upd_req_i   (upd_req_i),
    .upd_mask_i  (upd_mask_i),
    .upd_width_i (upd_width_i),
    .now_i       (now_us),
    .keep_due_i  (keep_due),
    .go_o        (go),
    .go_mask_o   (go_mask),
    .earliest_o  (earliest),
    .armed_o     (armed),
    .mask_nz_o   (mask_nz),
    .pending_o   (pending)
  );

  pace_strobe #(
    .NUM_GROUPS (NUM_GROUPS)
  ) i_strobe (
    .clk    (clk),
    .rst    (rst),
    .go_i   (go),
    .mask_i (go_mask),
    .trig_o (trig_o)
  );

  assign now_us_o = now_us;

  // R5: no strobe can appear before the first accepted trigger
  p_armed_before_strobe_r5: assert property (@(posedge clk) disable iff (rst)
    (|trig_o) |-> armed);

  // R4: a keep-alive never coincides with a held request
  p_keep_not_held_r4: assert property (@(posedge clk) disable iff (rst)
    keep_due |=> !pending);
endmodule

// File: tb/test_pace_trigger_sched.sv
module test_pace_trigger_sched;
  localparam int CLK_PERIOD = 10;
  localparam int NG   = 4;
  localparam int CPU  = 2;
  localparam int KEEP = 400;
  localparam int MAXP = 2300;
  localparam int GRD  = 50;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          upd_req = 1'b0;
  logic [NG-1:0] upd_mask = '0;
  logic [15:0]   upd_width = '0;
  logic [NG-1:0] trig;
  logic [31:0]   now_us;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  pace_trigger_sched #(
    .NUM_GROUPS (NG), .CLK_PER_US (CPU), .TIME_W (32), .WIDTH_W (16),
    .MAX_PULSE_US (MAXP), .GUARD_US (GRD), .KEEPALIVE_US (KEEP)
  ) i_pace_trigger_sched (
    .clk (clk), .rst (rst), .upd_req_i (upd_req), .upd_mask_i (upd_mask),
    .upd_width_i (upd_width), .trig_o (trig), .now_us_o (now_us)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int clampw(input int w);
    return (w > MAXP) ? MAXP : w;
  endfunction

  // Waits for a strobe; dt is the time base value seen by the firing edge
  task automatic wait_trig(input int limit, output bit found, output int m,
                           output longint dt, output int cyc);
    longint prev;
    prev = now_us;
    found = 0; m = 0; dt = 0; cyc = 0;
    while (!found && cyc < limit) begin
      @(negedge clk);
      upd_req = 1'b0;
      cyc++;
      if (trig != '0) begin
        found = 1; m = trig; dt = prev;
      end else begin
        prev = now_us;
      end
    end
    if (found) begin
      @(negedge clk);
      check(trig == '0, "R7 strobe one clock", trig, 0);
    end
  endtask

  task automatic req_wait(input int mask, input int w, input int limit, output bit found,
                          output int m, output longint dt, output int cyc);
    upd_req = 1'b1; upd_mask = NG'(mask); upd_width = 16'(w);
    wait_trig(limit, found, m, dt, cyc);
  endtask

  task automatic pulse_req(input int mask, input int w);
    upd_req = 1'b1; upd_mask = NG'(mask); upd_width = 16'(w);
    @(negedge clk);
    upd_req = 1'b0;
  endtask

  task automatic quiet(input int us, output int n);
    n = 0;
    for (int i = 0; i < us * CPU; i++) begin
      @(negedge clk);
      if (trig != '0) n++;
    end
  endtask

  initial begin
    bit found; int m; longint dt; int cyc; int n;
    longint lastf; int lastw; longint t0;

    repeat (4) @(negedge clk);
    check(trig == '0, "R9 trig in reset", trig, 0);
    check(now_us == 0, "R9 time in reset", now_us, 0);
    rst = 1'b0;
    @(negedge clk);
    check(trig == '0 && now_us <= 1, "R9 after reset", now_us, 0);

    // R8: rate of the time base
    t0 = now_us;
    repeat (10 * CPU) @(negedge clk);
    check(now_us == t0 + 10, "R8 time base rate", now_us, t0 + 10);

    // R5: no keep-alive before any trigger
    quiet(KEEP * 2, n);
    check(n == 0, "R5 no keepalive unarmed", n, 0);

    // R3: first request fires next clock with its mask
    req_wait(5, 100, 100, found, m, dt, cyc);
    check(found && cyc == 1, "R3 direct latency", cyc, 1);
    check(m == 5, "R7 strobe mask", m, 5);
    lastf = dt; lastw = 100;

    // R2/R3: early request held until window
    req_wait(3, 200, 20000, found, m, dt, cyc);
    check(m == 3, "R3 held mask", m, 3);
    check(dt == lastf + lastw + GRD, "R2 held fire time", dt, lastf + lastw + GRD);
    lastf = dt; lastw = 200;

    // R1: clamp of widest pulse
    req_wait(15, 5000, 20000, found, m, dt, cyc);
    check(dt == lastf + lastw + GRD && m == 15, "R2 fire after 200", dt, lastf + lastw + GRD);
    lastf = dt; lastw = clampw(5000);

    // R6: request during hold is dropped
    upd_req = 1'b1; upd_mask = 4'd1; upd_width = 16'd10;
    @(negedge clk);
    upd_req = 1'b0;
    repeat (20) @(negedge clk);
    pulse_req(8, 3000);
    wait_trig(20000, found, m, dt, cyc);
    check(dt == lastf + MAXP + GRD, "R1 clamped gap", dt, lastf + MAXP + GRD);
    check(m == 1, "R6 dropped mask ignored", m, 1);
    lastf = dt; lastw = 10;
    quiet(lastw + GRD + 20, n);
    check(n == 0, "R6 no strobe from dropped request", n, 0);

    // R4: keep-alive refires, twice
    wait_trig(20000, found, m, dt, cyc);
    check(found && dt == lastf + lastw + GRD + KEEP + 1, "R4 keepalive time", dt, lastf + lastw + GRD + KEEP + 1);
    check(m == 1, "R4 keepalive mask", m, 1);
    lastf = dt;
    wait_trig(20000, found, m, dt, cyc);
    check(found && dt == lastf + lastw + GRD + KEEP + 1, "R4 keepalive repeat", dt, lastf + lastw + GRD + KEEP + 1);
    lastf = dt;

    // R3: request past the window fires at once
    quiet(100, n);
    req_wait(6, 0, 100, found, m, dt, cyc);
    check(found && cyc == 1 && m == 6, "R3 late request direct", cyc, 1);
    lastf = dt; lastw = 0;

    // R5: zero mask stops keep-alive
    quiet(100, n);
    pulse_req(0, 10);
    quiet(KEEP * 3, n);
    check(n == 0, "R5 zero mask silences", n, 0);

    // Sweep of all masks with growing widths, back-to-back
    req_wait(1, 200, 100, found, m, dt, cyc);
    check(cyc == 1 && m == 1, "R3 sweep first direct", cyc, 1);
    lastf = dt; lastw = 200;
    for (int k = 2; k < (1 << NG); k++) begin
      req_wait(k, k * 200, 20000, found, m, dt, cyc);
      check(m == k, "R7 sweep mask", m, k);
      check(dt == lastf + lastw + GRD, "R2 sweep gap", dt, lastf + lastw + GRD);
      lastf = dt; lastw = clampw(k * 200);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(negedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule